// File: doc/BRIEF.md
# Quadratic Feedback Shift Register Period Tester

This block decides whether a candidate nonlinear feedback shift register of length `L` reaches the longest cycle it can have. The feedback bit is an XOR of chosen single cells and chosen products of two distinct cells. A coefficient vector applied at run time picks those terms. A host presents the coefficient vector and a nonzero seed, then pulses `start`. The block loads the seed and advances the register by one state per clock. It counts the steps until the state matches the seed again.

With no constant term, the all-zero state always maps to itself. The longest cycle is therefore the one through all `2^L - 1` nonzero states, and a candidate passes only when the seed comes back after exactly that many steps. A return before that point ends the test as a fail and keeps the measured cycle length. If the seed has not come back after `2^L` steps, the state has fallen into a cycle that does not contain it. The test then stops with a fail and sets a no-return flag. While the test runs, the cell at the output end of the register is presented as a bit stream, one bit per clock.

Top module: `qnl_period_tester`

## Requirements
- R1: Coefficient bit `k` for `k < L` enables the linear term for cell `k`. Bits from `L` upward enable the products of cells `(i,j)` with `i<j`, listed with `i` as the outer key and `j` as the inner key. For example, with L=4, bits 4..9 are (0,1),(0,2),(0,3),(1,2),(1,3),(2,3). The feedback is the XOR of all enabled terms. One step shifts the state toward cell 0 and writes the feedback into cell `L-1`.
- R2: `out_bit` shows cell 0 of the state. On the first cycle after start is accepted, it equals bit 0 of the seed. After `n` steps, it equals cell 0 of the state reached after `n` steps.
- R3: The state advances by exactly one step per clock. `done` is a single-cycle pulse that appears `p` clocks after the accepting edge, where `p` is the number of steps to the first return. `busy` falls in the same cycle.
- R4: `pass` is 1 only when the seed returns after exactly `2^L - 1` steps.
- R5: If the seed returns after fewer steps, `pass` is 0, `no_return` is 0, and `period` holds the step count. With a zero seed, this gives `period` = 1.
- R6: If no return has happened after `2^L` steps, the test stops with `no_return` = 1, `pass` = 0 and `period` = `2^L`.
- R7: The coefficient vector and the seed are captured only at the accepted start. Changing them later does not change the result.
- R8: A `start` pulse while `busy` is high is ignored. The running test finishes with its original result.
- R9: After reset, `busy`, `done`, `pass` and `no_return` are 0, and `period` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test; accepted only when idle |
| coef | input | L(L+1)/2 | Feedback term enables |
| seed | input | L | Initial register state |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Maximal cycle found |
| no_return | output | 1 | Seed not revisited within 2^L steps |
| period | output | L+1 | Measured step count |
| out_bit | output | 1 | Output cell of the register |

## Verification
The bench builds the tester with L=4. This gives 10 coefficient bits and at most 16 steps per run, so a reference walk over all states settles every candidate quickly. At that size, a linear maximal candidate, short rotations, a zero seed, an all-zero feedback that never returns, and several mixed linear and product sets can all be run within one short bench. The no-return limit and the `2^L - 1` pass boundary are both exercised exactly.

// File: rtl/qnl_pkg.sv
package qnl_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} qnl_st_e;

  // position of product term (i,j), i<j, in the coefficient vector
  function automatic int pair_idx(input int l, input int i, input int j);
    return l + (i * (2 * l - i - 1)) / 2 + (j - i - 1);
  endfunction
endpackage

// File: rtl/qnl_feedback.sv
module qnl_feedback #(
  parameter int L = 29,
  localparam int NC = L * (L + 1) / 2
) (
  input  logic [L-1:0]  state,
  input  logic [NC-1:0] coef,
  output logic          fb
);
  logic [NC-1:0] term;

  for (genvar i = 0; i < L; i++) begin : g_lin
    assign term[i] = coef[i] & state[i];
  end

  for (genvar i = 0; i < L; i++) begin : g_row
    for (genvar j = i + 1; j < L; j++) begin : g_col
      localparam int PI = qnl_pkg::pair_idx(L, i, j);
      assign term[PI] = coef[PI] & state[i] & state[j];
    end
  end

  assign fb = ^term;
endmodule

// File: rtl/qnl_shifter.sv
module qnl_shifter #(
  parameter int L = 29,
  localparam int NC = L * (L + 1) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [L-1:0]  seed,
  input  logic [NC-1:0] coef,
  output logic [L-1:0]  state,
  output logic          hit
);
  logic [L-1:0]  state_q, state_n, seed_q, nxt;
  logic [NC-1:0] coef_q, coef_n;
  logic [L-1:0]  seed_n;
  logic          fb;

  qnl_feedback #(.L(L)) u_fb (
    .state (state_q),
    .coef  (coef_q),
    .fb    (fb)
  );

  assign nxt = {fb, state_q[L-1:1]};
  assign hit = (nxt == seed_q);

  always_comb begin
    state_n = state_q;
    seed_n  = seed_q;
    coef_n  = coef_q;
    if (load) begin
      state_n = seed;
      seed_n  = seed;
      coef_n  = coef;
    end else if (adv) begin
      state_n = nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      seed_q  <= '0;
      coef_q  <= '0;
    end else begin
      state_q <= state_n;
      seed_q  <= seed_n;
      coef_q  <= coef_n;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/qnl_ctrl.sv
module qnl_ctrl #(
  parameter int L = 29,
  localparam int CW = L + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hit,
  output logic          load,
  output logic          adv,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          no_return,
  output logic [CW-1:0] period
);
  import qnl_pkg::*;

  localparam logic [CW-1:0] MAX_CNT  = {1'b0, {L{1'b1}}};
  localparam logic [CW-1:0] FULL_CNT = {1'b1, {L{1'b0}}};

  qnl_st_e       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n, per_q, per_n, step;
  logic          done_q, done_n, pass_q, pass_n, nr_q, nr_n;

  assign step = cnt_q + 1'b1;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    per_n  = per_q;
    pass_n = pass_q;
    nr_n   = nr_q;
    done_n = 1'b0;
    load   = 1'b0;
    adv    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          load   = 1'b1;
          st_n   = ST_RUN;
          cnt_n  = '0;
          per_n  = '0;
          pass_n = 1'b0;
          nr_n   = 1'b0;
        end
      end
      default: begin
        adv   = 1'b1;
        cnt_n = step;
        if (hit) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
          per_n  = step;
          pass_n = (step == MAX_CNT);
        end else if (step == FULL_CNT) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
          per_n  = step;
          nr_n   = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      per_q  <= '0;
      pass_q <= 1'b0;
      nr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      per_q  <= per_n;
      pass_q <= pass_n;
      nr_q   <= nr_n;
      done_q <= done_n;
    end
  end

  assign busy      = (st_q == ST_RUN);
  assign done      = done_q;
  assign pass      = pass_q;
  assign no_return = nr_q;
  assign period    = per_q;
endmodule

// File: rtl/qnl_period_tester.sv
module qnl_period_tester #(
  parameter int L = 29,
  localparam int NC = L * (L + 1) / 2,
  localparam int CW = L + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NC-1:0] coef,
  input  logic [L-1:0]  seed,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          no_return,
  output logic [CW-1:0] period,
  output logic          out_bit
);
  logic         load, adv, hit;
  logic [L-1:0] state;

  qnl_shifter #(.L(L)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .adv   (adv),
    .seed  (seed),
    .coef  (coef),
    .state (state),
    .hit   (hit)
  );

  qnl_ctrl #(.L(L)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hit       (hit),
    .load      (load),
    .adv       (adv),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .no_return (no_return),
    .period    (period)
  );

  assign out_bit = state[0];
endmodule

// File: rtl/qnl_checker.sv
module qnl_checker #(
  parameter int L = 29,
  localparam int CW = L + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          no_return,
  input logic [CW-1:0] period
);
  localparam logic [CW-1:0] MAX_CNT  = {1'b0, {L{1'b1}}};
  localparam logic [CW-1:0] FULL_CNT = {1'b1, {L{1'b0}}};

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_pass_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (period == MAX_CNT && !no_return));

  a_r6_noret: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_return) |-> (period == FULL_CNT && !pass));

  a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (period != '0));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  a_r8_rise_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind qnl_period_tester qnl_checker #(.L(L)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .no_return (no_return),
  .period    (period)
);

// File: tb/tb_qnl_period_tester.sv
module tb_qnl_period_tester;
  localparam int L  = 4;
  localparam int NC = L * (L + 1) / 2;
  localparam int CW = L + 1;
  localparam int NV = 10;
  localparam logic [NC+L-1:0] VEC [NV] = '{
    {10'h003, 4'h1}, {10'h003, 4'h9}, {10'h001, 4'h1}, {10'h001, 4'h5},
    {10'h000, 4'h1}, {10'h000, 4'h0}, {10'h243, 4'h3}, {10'h3FF, 4'h1},
    {10'h151, 4'h7}, {10'h08B, 4'hE}
  };

  logic clk, rst_n, start, busy, done, pass, no_return, out_bit;
  logic [NC-1:0] coef;
  logic [L-1:0]  seed;
  logic [CW-1:0] period;
  int total, bad;
  bit finished;

  qnl_period_tester #(.L(L)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .coef(coef), .seed(seed),
    .busy(busy), .done(done), .pass(pass), .no_return(no_return),
    .period(period), .out_bit(out_bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: one step of the quadratic register
  function automatic logic [L-1:0] ref_step(input logic [L-1:0] s, input logic [NC-1:0] c);
    logic f;
    int k;
    f = 1'b0;
    for (int i = 0; i < L; i++) f ^= c[i] & s[i];
    k = L;
    for (int i = 0; i < L; i++)
      for (int j = i + 1; j < L; j++) begin
        f ^= c[k] & s[i] & s[j];
        k++;
      end
    return {f, s[L-1:1]};
  endfunction

  function automatic int ref_period(input logic [NC-1:0] c, input logic [L-1:0] sd);
    logic [L-1:0] s;
    s = sd;
    for (int n = 1; n <= (1 << L); n++) begin
      s = ref_step(s, c);
      if (s == sd) return n;
    end
    return -1;
  endfunction

  // mode 0: plain; 1: change coef/seed after start; 2: extra start while busy
  task automatic run_one(input logic [NC-1:0] c, input logic [L-1:0] sd, input int mode);
    int p, exp_per, exp_pass, exp_nr, n;
    logic [L-1:0] s;
    p        = ref_period(c, sd);
    exp_nr   = (p < 0) ? 1 : 0;
    exp_per  = (p < 0) ? (1 << L) : p;
    exp_pass = (p == (1 << L) - 1) ? 1 : 0;
    @(negedge clk);
    coef = c; seed = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode == 1) begin coef = ~c; seed = ~sd; end
    chk("R2 out_bit at seed", int'(out_bit), int'(sd[0]));
    chk("R3 busy after start", int'(busy), 1);
    s = sd;
    n = 0;
    while (!done && n <= (1 << L) + 2) begin
      @(negedge clk);
      n++;
      s = ref_step(s, c);
      if (mode == 2 && n == 2 && !done) begin
        coef = '0; seed = '0; start = 1'b1;
      end else start = 1'b0;
      if (!done) chk("R2 out_bit stream", int'(out_bit), int'(s[0]));
    end
    start = 1'b0;
    chk("R3 done latency", n, exp_per);
    chk("R3 busy low at done", int'(busy), 0);
    chk("R5 period", int'(period), exp_per);
    chk("R4 pass", int'(pass), exp_pass);
    chk("R6 no_return", int'(no_return), exp_nr);
    @(negedge clk);
    chk("R3 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; coef = '0; seed = '0;
    repeat (3) @(negedge clk);
    // R9 reset values
    chk("R9 busy", int'(busy), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 pass", int'(pass), 0);
    chk("R9 no_return", int'(no_return), 0);
    chk("R9 period", int'(period), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R5 R6: vector table against the reference walk
    for (int v = 0; v < NV; v++)
      run_one(VEC[v][NC+L-1:L], VEC[v][L-1:0], 0);

    // R4 boundary: known linear maximal set gives 15
    chk("R4 linear max reference", ref_period(10'h003, 4'h1), 15);
    // R5 zero seed returns after one step
    chk("R5 zero seed reference", ref_period(10'h000, 4'h0), 1);

    // R7 inputs changed after accepted start
    run_one(10'h003, 4'h1, 1);
    run_one(10'h001, 4'h3, 1);
    // R8 start while busy ignored
    run_one(10'h003, 4'h6, 2);
    run_one(10'h000, 4'h8, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule